// File: doc/BRIEF.md
# SPI Byte Master with Register Interface

This block is a byte-wide SPI master that a processor controls through three
registers on a small synchronous bus: a control register, a status register
and a data register. Writing the data register while the block is enabled and
idle starts one full-duplex exchange. The byte written goes out on `mosi` while
the byte coming back on `miso` is gathered in the same shift register. When the
last bit has been shifted, the serial clock stops. The received byte is then
copied into a receive buffer and a completion flag is raised. If interrupts are
enabled, that flag also drives `irq`.

The serial clock is produced by a prescaler from the system clock. A 2-bit rate
field picks a base divisor of 4, 16, 64 or 128. A double-speed bit halves that
divisor. Together they give seven distinct SCK rates, from clk/2 to clk/128.
Either bit order can be chosen. The transmit side has a single buffer, so a data
write during an exchange is refused. Such a write sets a collision flag and does
not disturb the bits on the wire. The slave-select output is a plain level that
software sets in the control register. Both flags are cleared in two steps:
first a status read that sees the flag set, then any access to the data
register.

Register map (`bus_addr`): 0 = control, 1 = status, 2 = data. Address 3 reads
as zero. Control bits: [0] enable, [1] interrupt enable, [2] bit order
(0 = MSB first, 1 = LSB first), [4:3] rate field, [5] double speed, [6]
slave-select level. Status bits: [0] transfer complete, [1] write collision.

Top module: `spi_byte_master`

## Requirements
- R1: A write to address 2 while control bit 0 is 1 and no exchange is running starts an exchange of exactly 8 SCK rising edges, and the bits on `mosi` sampled at those edges form the written byte.
- R2: After the 8th SCK falling edge, SCK stays low and status bit 0 reads 1. Counting from the clock edge that takes the data write, the flag is visible 8×D system clocks later, where D is the selected divisor.
- R3: `irq` is 1 exactly when status bit 0 is 1 and control bit 1 is 1.
- R4: Control bit 2 selects the bit order: 0 sends and receives MSB first, 1 sends and receives LSB first.
- R5: The SCK period is D system clocks. For rate field r, D is 4, 16, 64 or 128 (r = 0..3). Control bit 5 halves D, giving 2, 8, 32 or 64.
- R6: A write to address 2 during an exchange sets status bit 1, and it changes neither the bits sent on `mosi` nor the byte received.
- R7: After an exchange, a read of address 2 returns the byte received from `miso`. The value stays until the next exchange completes.
- R8: A status flag that is 1 is cleared by a read of address 2 or a write to it, but only when a status read that saw it at 1 came first. An access to address 2 with no such read leaves the flag at 1.
- R9: SCK idles low. `mosi` changes only when SCK falls or when an exchange is loaded, and `miso` is sampled when SCK rises.
- R10: `ss_n` equals control bit 6, which is 1 after reset.
- R11: A write to address 2 while control bit 0 is 0 produces no SCK edge and sets no flag. Clearing control bit 0 during an exchange stops it with SCK low and no completion flag.
- R12: After reset, control reads 0x40, status and data read 0, and `sck` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe for the current cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data, valid while a read is selected, else 0 |
| irq | output | 1 | Interrupt request |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Slave-select level from control bit 6 |

## Verification
Every one of the 256 byte values is exchanged at the fastest rate. The bit order
alternates, and the slave returns a value that differs from the byte sent, so
the bits on `mosi`, the received byte, and any mix-up between the two
directions or the two orders are each seen separately. All eight rate codes are
then swept in both bit orders with the patterns all-zero, all-one, alternating
and a single set bit. At each rate the measured SCK period and the
write-to-flag latency are compared with the divisor computed in the bench,
which tells apart a wrong divisor, a missing halving and an off-by-one in the
count. Separate sequences then cover a collision write in mid-exchange, the
two-step flag clear with and without the status read first, writes while
disabled, an abort, slave-select control and interrupt gating.

// File: rtl/spim_pkg.sv
package spim_pkg;

   // register addresses
   typedef enum logic [1:0] {
      ADDR_CTRL = 2'd0,
      ADDR_STAT = 2'd1,
      ADDR_DATA = 2'd2,
      ADDR_NONE = 2'd3
   } spim_addr_e;

   // control register layout, MSB first
   typedef struct packed {
      logic       ss_lvl;     // [6]
      logic       dbl;        // [5]
      logic [1:0] rate;       // [4:3]
      logic       lsb_first;  // [2]
      logic       irq_en;     // [1]
      logic       enable;     // [0]
   } spim_ctrl_t;

   localparam int CTRL_W     = $bits(spim_ctrl_t);
   localparam int RATE_CODES = 8;   // {dbl, rate}
   localparam spim_ctrl_t CTRL_RESET = 7'b100_0000;

   // divisor of the system clock for code {dbl, rate}
   function automatic int unsigned spim_divisor(input int unsigned code);
      int unsigned r;
      int unsigned base;
      r = code & 3;
      if (r == 3) base = 128;
      else        base = 4 << (2 * r);
      if ((code & 4) != 0) return base / 2;
      return base;
   endfunction

endpackage

// File: rtl/spim_clkgen.sv
module spim_clkgen
   import spim_pkg::*;
#(
   parameter int MAX_DIV = 128
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic       restart,
   input  logic [2:0] code,
   output logic       tick
);

   localparam int HALF_W = $clog2(MAX_DIV);

   logic [HALF_W-1:0] half_tab [RATE_CODES];
   logic [HALF_W-1:0] cnt_q;

   for (genvar g = 0; g < RATE_CODES; g++) begin : g_rate
      localparam int unsigned DV = spim_divisor(g);
      if (DV < 2 || DV > MAX_DIV) begin : g_bad
         $error("spim_clkgen: divisor %0d of code %0d outside 2..MAX_DIV", DV, g);
      end
      assign half_tab[g] = HALF_W'(DV / 2 - 1);
   end

   assign tick = run && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run || restart) begin
         cnt_q <= half_tab[code];
      end else if (cnt_q == '0) begin
         cnt_q <= half_tab[code];
      end else begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              start,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              lsb_first,
   input  logic              tick,
   input  logic              miso,
   output logic              busy,
   output logic              sck,
   output logic              mosi,
   output logic              done_pulse,
   output logic [DATA_W-1:0] rx_next
);

   localparam int CW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);

   logic [DATA_W-1:0] sh_q;
   logic [CW-1:0]     bit_q;
   logic              busy_q;
   logic              sck_q;
   logic              samp_q;

   // shift register after the next falling edge
   assign rx_next = lsb_first ? {samp_q, sh_q[DATA_W-1:1]}
                              : {sh_q[DATA_W-2:0], samp_q};

   assign mosi       = lsb_first ? sh_q[0] : sh_q[DATA_W-1];
   assign busy       = busy_q;
   assign sck        = sck_q;
   assign done_pulse = busy_q && tick && sck_q && (bit_q == LAST) && enable;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         bit_q  <= '0;
         busy_q <= 1'b0;
         sck_q  <= 1'b0;
         samp_q <= 1'b0;
      end else if (!enable) begin
         busy_q <= 1'b0;
         sck_q  <= 1'b0;
         bit_q  <= '0;
      end else if (start) begin
         sh_q   <= tx_data;
         busy_q <= 1'b1;
         sck_q  <= 1'b0;
         bit_q  <= '0;
      end else if (busy_q && tick) begin
         if (!sck_q) begin
            sck_q  <= 1'b1;
            samp_q <= miso;
         end else begin
            sck_q <= 1'b0;
            sh_q  <= rx_next;
            bit_q <= bit_q + 1'b1;
            if (bit_q == LAST) busy_q <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/spim_regs.sv
module spim_regs
   import spim_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int BUS_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [1:0]        bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic              busy,
   input  logic              done_pulse,
   input  logic [DATA_W-1:0] rx_next,
   output spim_ctrl_t        ctrl,
   output logic              start,
   output logic              done_flag,
   output logic              wcol_flag,
   output logic              irq
);

   spim_ctrl_t        ctrl_q;
   logic [DATA_W-1:0] rx_buf_q;
   logic              done_q, wcol_q;
   logic              arm_done_q, arm_wcol_q;

   logic ctrl_wr, stat_rd, data_acc, data_wr, collide;
   logic unused_wbits;

   if (BUS_W > CTRL_W) begin : g_spare
      assign unused_wbits = ^bus_wdata[BUS_W-1:CTRL_W];
   end else begin : g_nospare
      assign unused_wbits = 1'b0;
   end

   assign ctrl_wr  = bus_sel && bus_wr && (bus_addr == ADDR_CTRL);
   assign stat_rd  = bus_sel && !bus_wr && (bus_addr == ADDR_STAT);
   assign data_acc = bus_sel && (bus_addr == ADDR_DATA);
   assign data_wr  = data_acc && bus_wr;
   assign start    = data_wr && ctrl_q.enable && !busy;
   assign collide  = data_wr && ctrl_q.enable && busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q     <= CTRL_RESET;
         rx_buf_q   <= '0;
         done_q     <= 1'b0;
         wcol_q     <= 1'b0;
         arm_done_q <= 1'b0;
         arm_wcol_q <= 1'b0;
      end else begin
         if (ctrl_wr) ctrl_q <= spim_ctrl_t'(bus_wdata[CTRL_W-1:0]);
         if (done_pulse) rx_buf_q <= rx_next;

         if (done_pulse)                   done_q <= 1'b1;
         else if (data_acc && arm_done_q)  done_q <= 1'b0;

         if (collide)                      wcol_q <= 1'b1;
         else if (data_acc && arm_wcol_q)  wcol_q <= 1'b0;

         if (data_acc) begin
            arm_done_q <= 1'b0;
            arm_wcol_q <= 1'b0;
         end else if (stat_rd) begin
            arm_done_q <= done_q;
            arm_wcol_q <= wcol_q;
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_sel && !bus_wr) begin
         case (spim_addr_e'(bus_addr))
            ADDR_CTRL: bus_rdata[CTRL_W-1:0] = ctrl_q;
            ADDR_STAT: bus_rdata[1:0]        = {wcol_q, done_q};
            ADDR_DATA: bus_rdata[DATA_W-1:0] = rx_buf_q;
            default:   bus_rdata             = '0;
         endcase
      end
   end

   assign ctrl      = ctrl_q;
   assign done_flag = done_q;
   assign wcol_flag = wcol_q;
   assign irq       = ctrl_q.irq_en && done_q;

endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
   import spim_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int BUS_W   = 8,
   parameter int MAX_DIV = 128
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_sel,
   input  logic             bus_wr,
   input  logic [1:0]       bus_addr,
   input  logic [BUS_W-1:0] bus_wdata,
   output logic [BUS_W-1:0] bus_rdata,
   output logic             irq,
   output logic             sck,
   output logic             mosi,
   input  logic             miso,
   output logic             ss_n
);

   if (DATA_W < 2 || DATA_W > BUS_W) begin : g_bad_data
      $error("spi_byte_master: DATA_W must be 2..BUS_W");
   end
   if (BUS_W < CTRL_W) begin : g_bad_bus
      $error("spi_byte_master: BUS_W narrower than the control register");
   end

   spim_ctrl_t        ctrl;
   logic              start, busy, tick, done_pulse;
   logic              done_flag, wcol_flag;
   logic [DATA_W-1:0] rx_next;

   spim_regs #(.DATA_W(DATA_W), .BUS_W(BUS_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_sel    (bus_sel),
      .bus_wr     (bus_wr),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .busy       (busy),
      .done_pulse (done_pulse),
      .rx_next    (rx_next),
      .ctrl       (ctrl),
      .start      (start),
      .done_flag  (done_flag),
      .wcol_flag  (wcol_flag),
      .irq        (irq)
   );

   spim_clkgen #(.MAX_DIV(MAX_DIV)) u_clkgen (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (busy),
      .restart (start),
      .code    ({ctrl.dbl, ctrl.rate}),
      .tick    (tick)
   );

   spim_shifter #(.DATA_W(DATA_W)) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (ctrl.enable),
      .start      (start),
      .tx_data    (bus_wdata[DATA_W-1:0]),
      .lsb_first  (ctrl.lsb_first),
      .tick       (tick),
      .miso       (miso),
      .busy       (busy),
      .sck        (sck),
      .mosi       (mosi),
      .done_pulse (done_pulse),
      .rx_next    (rx_next)
   );

   assign ss_n = ctrl.ss_lvl;

endmodule

// File: rtl/spim_chk.sv
module spim_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       bus_sel,
   input logic       bus_wr,
   input logic [1:0] bus_addr,
   input logic       wr_ss_bit,
   input logic       ctrl_en,
   input logic       busy,
   input logic       sck,
   input logic       mosi,
   input logic       ss_n,
   input logic       done_flag,
   input logic       wcol_flag
);

   logic data_wr, ctrl_wr;
   assign data_wr = bus_sel && bus_wr && (bus_addr == 2'd2);
   assign ctrl_wr = bus_sel && bus_wr && (bus_addr == 2'd0);

   // R9
   sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sck);

   // R1
   start_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(data_wr));

   // R2
   done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_flag) |-> ($past(busy) && !busy && !sck));

   // R6
   wcol_on_busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && busy && ctrl_en) |=> wcol_flag);

   // R9
   mosi_steady_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sck && $past(sck)) |-> $stable(mosi));

   // R10
   ss_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr |=> (ss_n == $past(wr_ss_bit)));

endmodule

bind spi_byte_master spim_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .wr_ss_bit (bus_wdata[6]),
   .ctrl_en   (ctrl.enable),
   .busy      (busy),
   .sck       (sck),
   .mosi      (mosi),
   .ss_n      (ss_n),
   .done_flag (done_flag),
   .wcol_flag (wcol_flag)
);

// File: tb/tb_spi_byte_master.sv
`timescale 1ns/1ps
module tb_spi_byte_master;

   localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_DATA = 2'd2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_sel = 1'b0, bus_wr = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       irq, sck, mosi, miso, ss_n;

   always #4 clk = ~clk;   // 125 MHz

   spi_byte_master dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq(irq), .sck(sck), .mosi(mosi), .miso(miso), .ss_n(ss_n)
   );

   int  n_chk = 0, n_bad = 0;
   bit  ended = 1'b0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   // slave model: mode 0, same bit order as the master
   logic [7:0] slv_sh = 8'h00, cap = 8'h00;
   logic       slv_lsb = 1'b0;
   int         rises = 0;
   time        t_first = 0, t_last = 0;
   int         mode_viol = 0;
   logic       pm = 1'b0, ps = 1'b0;

   assign miso = slv_lsb ? slv_sh[0] : slv_sh[7];

   always @(posedge sck) begin
      cap = slv_lsb ? {mosi, cap[7:1]} : {cap[6:0], mosi};
      if (rises == 0) t_first = $time;
      t_last = $time;
      rises++;
   end
   always @(negedge sck) begin
      slv_sh = slv_lsb ? {1'b0, slv_sh[7:1]} : {slv_sh[6:0], 1'b0};
   end
   always @(negedge clk) begin
      if (mosi !== pm && sck && ps) mode_viol++;
      pm = mosi;
      ps = sck;
   end

   // bus access tasks, entered at a falling clock edge
   task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   function automatic int bdiv(input logic [2:0] code);
      int b;
      b = (code[1:0] == 2'd3) ? 128 : (4 << (2 * code[1:0]));
      return code[2] ? b / 2 : b;
   endfunction

   function automatic logic [7:0] ctl(input logic ss, input logic [2:0] code,
                                      input logic lsb, input logic ie, input logic en);
      return {1'b0, ss, code[2], code[1:0], lsb, ie, en};
   endfunction

   task automatic arm_slave(input logic lsb, input logic [7:0] s);
      slv_lsb = lsb; slv_sh = s; cap = 8'h00; rises = 0;
   endtask

   // one full exchange with all per-transfer checks
   task automatic xfer(input logic [2:0] code, input logic lsb, input logic ie,
                       input logic [7:0] tx, input logic [7:0] slv);
      logic [7:0] s, r;
      int k, d;
      d = bdiv(code);
      bus_write(A_CTRL, ctl(1'b0, code, lsb, ie, 1'b1));
      arm_slave(lsb, slv);
      bus_write(A_DATA, tx);
      k = 0;
      forever begin
         bus_read(A_STAT, s);
         if (s[0] || k > 5000) break;
         k++;
      end
      chk("R2 completion latency", k, 8 * d);
      chk("R3 irq with flag set", irq, ie);
      chk("R1 sck rising edges", rises, 8);
      chk("R1 R4 mosi byte", cap, tx);
      chk("R5 sck period ns", 32'(t_last - t_first), 7 * d * 8);
      bus_read(A_DATA, r);
      chk("R7 received byte", r, slv);
      bus_read(A_STAT, s);
      chk("R8 flags cleared", s, 8'h00);
      chk("R2 sck stopped", {sck, 8'(rises)}, {1'b0, 8'd8});
   endtask

   initial begin
      #(8 * 190000);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic [7:0] s, r;
      repeat (3) @(negedge clk);
      // R12 reset state
      chk("R12 sck", sck, 1'b0);
      chk("R12 irq", irq, 1'b0);
      chk("R10 ss_n reset", ss_n, 1'b1);
      rst_n = 1'b1;
      @(negedge clk);
      bus_read(A_CTRL, r); chk("R12 control", r, 8'h40);
      bus_read(A_STAT, r); chk("R12 status", r, 8'h00);
      bus_read(A_DATA, r); chk("R12 data", r, 8'h00);

      // R10 slave select level
      bus_write(A_CTRL, 8'h00); chk("R10 ss_n low", ss_n, 1'b0);
      bus_write(A_CTRL, 8'h40); chk("R10 ss_n high", ss_n, 1'b1);

      // R11 writes ignored while disabled
      arm_slave(1'b0, 8'h00);
      bus_write(A_DATA, 8'h77);
      repeat (60) @(negedge clk);
      chk("R11 no sck when disabled", rises, 0);
      bus_read(A_STAT, r); chk("R11 no flag when disabled", r, 8'h00);

      // R1 R4 R7 all byte values at clk/2
      for (int v = 0; v < 256; v++) begin
         xfer(3'b100, v[0], 1'b1, 8'(v), 8'(v * 37 + 11) ^ 8'h5A);
      end

      // R5 every rate code, both orders, several patterns
      for (int c = 0; c < 8; c++) begin
         for (int o = 0; o < 2; o++) begin
            xfer(3'(c), o[0], 1'b0, 8'h00, 8'hFF);
            xfer(3'(c), o[0], 1'b1, 8'hFF, 8'h00);
            xfer(3'(c), o[0], 1'b1, 8'hA5, 8'h5A);
            xfer(3'(c), o[0], 1'b0, 8'h01, 8'h80);
         end
      end

      // R3 irq gating by control bit 1
      bus_write(A_CTRL, ctl(1'b0, 3'b100, 1'b0, 1'b0, 1'b1));
      arm_slave(1'b0, 8'h42);
      bus_write(A_DATA, 8'h24);
      repeat (24) @(negedge clk);
      chk("R3 irq masked", irq, 1'b0);
      bus_write(A_CTRL, ctl(1'b0, 3'b100, 1'b0, 1'b1, 1'b1));
      chk("R3 irq unmasked", irq, 1'b1);

      // R8 data access without a prior status read keeps the flag
      bus_read(A_DATA, r);
      chk("R7 byte kept", r, 8'h42);
      bus_read(A_STAT, s); chk("R8 flag survives unarmed access", s, 8'h01);
      bus_read(A_DATA, r);
      bus_read(A_STAT, s); chk("R8 flag cleared after arm", s, 8'h00);
      bus_read(A_DATA, r); chk("R7 byte held after clear", r, 8'h42);

      // R6 collision write during an exchange
      bus_write(A_CTRL, ctl(1'b0, 3'b001, 1'b0, 1'b0, 1'b1));
      arm_slave(1'b0, 8'h96);
      bus_write(A_DATA, 8'hC3);
      repeat (30) @(negedge clk);
      bus_write(A_DATA, 8'h3C);
      repeat (140) @(negedge clk);
      bus_read(A_STAT, s); chk("R6 both flags", s, 8'h03);
      chk("R6 mosi unaffected", cap, 8'hC3);
      chk("R6 edge count unaffected", rises, 8);
      bus_read(A_DATA, r); chk("R6 received unaffected", r, 8'h96);
      bus_read(A_STAT, s); chk("R8 both flags cleared", s, 8'h00);

      // R11 abort by clearing enable
      bus_write(A_CTRL, ctl(1'b0, 3'b011, 1'b0, 1'b0, 1'b1));
      arm_slave(1'b0, 8'h11);
      bus_write(A_DATA, 8'hE7);
      repeat (200) @(negedge clk);
      bus_write(A_CTRL, ctl(1'b0, 3'b011, 1'b0, 1'b0, 1'b0));
      @(negedge clk);
      chk("R11 sck low after abort", sck, 1'b0);
      repeat (1100) @(negedge clk);
      chk("R11 abort cut edges", rises < 8, 1'b1);
      bus_read(A_STAT, s); chk("R11 no flag after abort", s, 8'h00);

      chk("R9 mosi changed while sck high", mode_viol, 0);
      finish_run();
   end

endmodule